// File: doc/BRIEF.md
# Flash Octal-DDR Mode Sequencer

This block moves a serial NOR flash between its single-line mode and its octal double-data-rate mode, and it keeps a record of which mode the flash is in. A client asks for a mode with a one-cycle request pulse and receives a one-cycle completion pulse, which carries an error flag. Between these two pulses the sequencer sends the needed commands to a lower-level command engine. Each command goes out on a valid/ready handshake and is then acknowledged by a response pulse that reports pass or fail.

Entering octal DDR takes one configuration write, sent over the single line. Leaving octal DDR takes a two-step soft reset, sent in octal DTR, with a one-microsecond pause after each step. The block also outputs the read settings for the mode that is currently committed: read opcode, dummy cycles, address width and protocol. A read wrapper asks for the preferred mode before each read. When the read ends, whether it succeeds or fails, the wrapper asks for single mode again.

Top module: `flash_mode_seq`

## Requirements
- R1: A request for the mode that is already current raises `req_done` on the next cycle with `req_err` low, and no command is issued.
- R2: A request for octal mode (`req_mode`=1) while in single mode issues one command: opcode 0x81, address 0 with `cmd_addr_bytes`=3, `cmd_has_data`=1, data 0xE7, `cmd_proto`=0 (1-1-1). The request completes after that command's passing response, with no wait.
- R3: A request for single mode (`req_mode`=0) while in octal mode issues opcode 0x66 and then opcode 0x99, in that order. Both are sent with `cmd_proto`=1 (8-8-8 DTR), `cmd_addr_bytes`=0 and `cmd_has_data`=0.
- R4: After the passing response to each exit command, the sequencer waits WAIT_CYCLES = CLK_FREQ_HZ/1e6 cycles (rounded up) before it issues the next command or completes. At 50 MHz, the second command appears on the 51st cycle after the first response.
- R5: While `cur_mode`=1, the read settings are `rd_opcode`=0xFD, `rd_dummy`=16, `rd_addr_bytes`=4 and `rd_proto`=1.
- R6: While `cur_mode`=0, the read settings are `rd_opcode`=0x0C, `rd_dummy`=8, `rd_addr_bytes`=4 and `rd_proto`=0.
- R7: `cur_mode` and the read settings change only in the cycle where a successful completion is reported. They keep the values from before the switch while the sequence runs.
- R8: A response with `cmd_resp_fail`=1 ends the sequence at once. `req_done` and `req_err` pulse together, `cur_mode` is left unchanged, and no further command is issued.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and every command field stay unchanged.
- R10: A `req_valid` pulse that arrives while a switch is in progress is ignored. It produces no extra completion and does not change the result.
- R11: After reset, `cur_mode` is 0 (single), and `cmd_valid`, `req_done` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request pulse |
| req_mode | input | 1 | Requested mode: 0 single, 1 octal DDR |
| req_done | output | 1 | Request completion pulse |
| req_err | output | 1 | Set with req_done when a command failed |
| cur_mode | output | 1 | Committed mode |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 32 | Command address |
| cmd_addr_bytes | output | 3 | Address byte count |
| cmd_proto | output | 1 | 0 = 1-1-1, 1 = 8-8-8 DTR |
| cmd_has_data | output | 1 | One data byte follows |
| cmd_data | output | 8 | Data byte |
| cmd_resp_valid | input | 1 | Command response pulse |
| cmd_resp_fail | input | 1 | Response reports failure |
| rd_opcode | output | 8 | Read opcode for the committed mode |
| rd_dummy | output | 5 | Read dummy cycles |
| rd_addr_bytes | output | 3 | Read address byte count |
| rd_proto | output | 1 | Read protocol |

## Verification
If the committed mode register holds a wrong value, the fault shows on the read-setting outputs in that same cycle. The next request also shows it, because it would issue commands when none are due, or skip commands that are due. A fault in the step or target registers shows as a wrong or reordered opcode at the very next command offer. A fault in the wait counter shows as a gap after a 0x66 response that differs from 51 cycles. A lost error path leaves the mode changed after a failing response, and this is visible at the completion pulse.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RESP,
        ST_DELAY
    } seq_state_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [31:0] addr;
        logic [2:0]  addr_bytes;
        logic        proto;
        logic        has_data;
        logic [7:0]  data;
    } flash_cmd_t;

    localparam logic [7:0] OP_CFG_WRITE   = 8'h81;
    localparam logic [7:0] CFG_OCTAL_DDR  = 8'hE7;
    localparam logic [7:0] OP_RST_ENABLE  = 8'h66;
    localparam logic [7:0] OP_RST_MEMORY  = 8'h99;
    localparam logic [7:0] OP_RD_OCTAL    = 8'hFD;
    localparam logic [7:0] OP_RD_FAST_4B  = 8'h0C;
    localparam logic       PROTO_SINGLE   = 1'b0;
    localparam logic       PROTO_OCT_DTR  = 1'b1;

endpackage

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        expired = run && (count_q == CNT_W'(CYCLES - 1));
        if (!run || expired) count_d = '0;
        else                 count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/flash_switch_steps.sv
module flash_switch_steps
    import flash_mode_pkg::*;
(
    input  logic       target,
    input  logic       step,
    output flash_cmd_t cmd,
    output logic       is_last,
    output logic       wait_after
);
    always_comb begin
        cmd = '0;
        if (target) begin
            cmd.opcode     = OP_CFG_WRITE;
            cmd.addr_bytes = 3'd3;
            cmd.proto      = PROTO_SINGLE;
            cmd.has_data   = 1'b1;
            cmd.data       = CFG_OCTAL_DDR;
            is_last        = 1'b1;
            wait_after     = 1'b0;
        end else begin
            cmd.opcode     = step ? OP_RST_MEMORY : OP_RST_ENABLE;
            cmd.proto      = PROTO_OCT_DTR;
            is_last        = step;
            wait_after     = 1'b1;
        end
    end
endmodule

// File: rtl/flash_rd_settings.sv
module flash_rd_settings
    import flash_mode_pkg::*;
#(
    parameter int DUMMY_W = 5
) (
    input  logic               mode,
    output logic [7:0]         rd_opcode,
    output logic [DUMMY_W-1:0] rd_dummy,
    output logic [2:0]         rd_addr_bytes,
    output logic               rd_proto
);
    always_comb begin
        rd_addr_bytes = 3'd4;
        if (mode) begin
            rd_opcode = OP_RD_OCTAL;
            rd_dummy  = DUMMY_W'(16);
            rd_proto  = PROTO_OCT_DTR;
        end else begin
            rd_opcode = OP_RD_FAST_4B;
            rd_dummy  = DUMMY_W'(8);
            rd_proto  = PROTO_SINGLE;
        end
    end
endmodule

// File: rtl/flash_mode_seq.sv
module flash_mode_seq
    import flash_mode_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_mode,
    output logic        req_done,
    output logic        req_err,
    output logic        cur_mode,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [7:0]  cmd_opcode,
    output logic [31:0] cmd_addr,
    output logic [2:0]  cmd_addr_bytes,
    output logic        cmd_proto,
    output logic        cmd_has_data,
    output logic [7:0]  cmd_data,
    input  logic        cmd_resp_valid,
    input  logic        cmd_resp_fail,
    output logic [7:0]  rd_opcode,
    output logic [4:0]  rd_dummy,
    output logic [2:0]  rd_addr_bytes,
    output logic        rd_proto
);
    localparam int WAIT_CYCLES = (CLK_FREQ_HZ + 999_999) / 1_000_000;

    typedef struct packed {
        seq_state_e state;
        logic       step;
        logic       target;
        logic       mode;
        logic       done;
        logic       err;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    flash_cmd_t step_cmd;
    logic       step_last, step_wait, wait_over, seq_busy;

    flash_switch_steps u_steps (
        .target     (r_q.target),
        .step       (r_q.step),
        .cmd        (step_cmd),
        .is_last    (step_last),
        .wait_after (step_wait)
    );

    flash_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.state == ST_DELAY),
        .expired (wait_over)
    );

    flash_rd_settings #(.DUMMY_W(5)) u_rd (
        .mode          (r_q.mode),
        .rd_opcode     (rd_opcode),
        .rd_dummy      (rd_dummy),
        .rd_addr_bytes (rd_addr_bytes),
        .rd_proto      (rd_proto)
    );

    always_comb begin
        logic advance;
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        advance  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mode == r_q.mode) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.target = req_mode;
                        r_d.step   = 1'b0;
                        r_d.state  = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) r_d.state = ST_WAIT_RESP;
            end
            ST_WAIT_RESP: begin
                if (cmd_resp_valid) begin
                    if (cmd_resp_fail) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else if (step_wait) begin
                        r_d.state = ST_DELAY;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (wait_over) advance = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (advance) begin
            if (step_last) begin
                r_d.mode  = r_q.target;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end else begin
                r_d.step  = 1'b1;
                r_d.state = ST_ISSUE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, step: 1'b0, target: 1'b0,
                     mode: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_busy       = (r_q.state != ST_IDLE);
    assign req_done       = r_q.done;
    assign req_err        = r_q.err;
    assign cur_mode       = r_q.mode;
    assign cmd_valid      = (r_q.state == ST_ISSUE);
    assign cmd_opcode     = step_cmd.opcode;
    assign cmd_addr       = step_cmd.addr;
    assign cmd_addr_bytes = step_cmd.addr_bytes;
    assign cmd_proto      = step_cmd.proto;
    assign cmd_has_data   = step_cmd.has_data;
    assign cmd_data       = step_cmd.data;
endmodule

// File: rtl/flash_mode_seq_chk.sv
module flash_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       req_valid,
    input logic       req_mode,
    input logic       req_done,
    input logic       req_err,
    input logic       cur_mode,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_opcode,
    input logic       cmd_proto,
    input logic [7:0] rd_opcode,
    input logic [4:0] rd_dummy
);
    a_r1_same_mode_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_mode == cur_mode) |=> (req_done && !req_err && !cmd_valid));

    a_r3_exit_cmds_octal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_opcode == 8'h66 || cmd_opcode == 8'h99)) |-> cmd_proto);

    a_r5_octal_read_set: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode |-> (rd_opcode == 8'hFD && rd_dummy == 5'd16));

    a_r7_mode_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode)) |-> (req_done && !req_err));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done);

    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_proto)));

    a_r11_no_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);
endmodule

bind flash_mode_seq flash_mode_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (seq_busy),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_done   (req_done),
    .req_err    (req_err),
    .cur_mode   (cur_mode),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_opcode (cmd_opcode),
    .cmd_proto  (cmd_proto),
    .rd_opcode  (rd_opcode),
    .rd_dummy   (rd_dummy)
);

// File: tb/sim_flash_mode_seq.sv
module sim_flash_mode_seq;
    localparam int WAIT = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_mode = 1'b0;
    logic cmd_ready = 1'b0, cmd_resp_valid = 1'b0, cmd_resp_fail = 1'b0;
    logic req_done, req_err, cur_mode, cmd_valid, cmd_proto, cmd_has_data, rd_proto;
    logic [7:0] cmd_opcode, cmd_data, rd_opcode;
    logic [31:0] cmd_addr;
    logic [2:0] cmd_addr_bytes, rd_addr_bytes;
    logic [4:0] rd_dummy;

    int checks = 0, errors = 0;

    logic [7:0] ops [4];
    logic       prs [4];
    logic [2:0] abs [4];
    logic       hds [4];
    logic [7:0] dts [4];
    logic [31:0] ads [4];

    always #10 clk = ~clk;

    flash_mode_seq #(.CLK_FREQ_HZ(50_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_done(req_done), .req_err(req_err), .cur_mode(cur_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_addr_bytes(cmd_addr_bytes), .cmd_proto(cmd_proto),
        .cmd_has_data(cmd_has_data), .cmd_data(cmd_data),
        .cmd_resp_valid(cmd_resp_valid), .cmd_resp_fail(cmd_resp_fail),
        .rd_opcode(rd_opcode), .rd_dummy(rd_dummy), .rd_addr_bytes(rd_addr_bytes),
        .rd_proto(rd_proto)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {exp_mode, exp_err, exp_n[1:0], stall[1:0], fail_idx[1:0], req_mode}
    localparam logic [8:0] VEC [9] = '{
        {1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 1'b0},
        {1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1},
        {1'b1, 1'b0, 2'd1, 2'd2, 2'd3, 1'b1},
        {1'b1, 1'b0, 2'd0, 2'd0, 2'd3, 1'b1},
        {1'b1, 1'b1, 2'd2, 2'd0, 2'd1, 1'b0},
        {1'b1, 1'b1, 2'd1, 2'd0, 2'd0, 1'b0},
        {1'b0, 1'b0, 2'd2, 2'd3, 2'd3, 1'b0},
        {1'b1, 1'b0, 2'd1, 2'd0, 2'd3, 1'b1},
        {1'b0, 1'b0, 2'd2, 2'd0, 2'd3, 1'b0}
    };

    task automatic run_req(input logic m, input int fail_idx, input int stall, input bit poke,
                           output int n, output bit err, output int gap,
                           output bit held_ok, output bit hold_ok);
        logic [7:0] exp_rd;
        logic [7:0] first_op;
        int phase, stall_cnt, resp_cyc;
        bit fin, seen;
        exp_rd = cur_mode ? 8'hFD : 8'h0C;
        n = 0; err = 0; gap = -1; held_ok = 1; hold_ok = 1;
        phase = 0; stall_cnt = 0; resp_cyc = -1; fin = 0; seen = 0; first_op = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        for (int c = 0; c < 3000 && !fin; c++) begin
            @(negedge clk);
            if (c == 0) req_valid = 1'b0;
            if (req_done) begin
                err = req_err; fin = 1;
                req_valid = 1'b0; cmd_ready = 1'b0; cmd_resp_valid = 1'b0;
            end else begin
                if (rd_opcode !== exp_rd) held_ok = 0;
                case (phase)
                    0: if (cmd_valid) begin
                        if (!seen) begin first_op = cmd_opcode; seen = 1; end
                        if (stall_cnt < stall) stall_cnt++;
                        else begin
                            if (n == 0 && cmd_opcode !== first_op) hold_ok = 0;
                            if (n < 4) begin
                                ops[n] = cmd_opcode; prs[n] = cmd_proto; abs[n] = cmd_addr_bytes;
                                hds[n] = cmd_has_data; dts[n] = cmd_data; ads[n] = cmd_addr;
                            end
                            if (n == 1 && resp_cyc >= 0) gap = c - resp_cyc;
                            cmd_ready = 1'b1; phase = 1;
                        end
                    end
                    1: begin
                        cmd_ready = 1'b0; cmd_resp_valid = 1'b1;
                        cmd_resp_fail = (n == fail_idx);
                        resp_cyc = c; n++; phase = 2;
                        if (poke) begin req_valid = 1'b1; req_mode = ~m; end
                    end
                    default: begin
                        cmd_resp_valid = 1'b0; req_valid = 1'b0; phase = 0;
                    end
                endcase
            end
        end
        if (!fin) chk(0, "R1 completion missing", 0, 1);
    endtask

    task automatic check_rd(input string tag);
        if (cur_mode) begin
            chk(rd_opcode == 8'hFD && rd_dummy == 5'd16 && rd_addr_bytes == 3'd4 && rd_proto == 1'b1,
                {tag, " R5 octal read settings"}, {rd_opcode, 3'(rd_dummy), rd_proto}, {8'hFD, 3'd0, 1'b1});
        end else begin
            chk(rd_opcode == 8'h0C && rd_dummy == 5'd8 && rd_addr_bytes == 3'd4 && rd_proto == 1'b0,
                {tag, " R6 single read settings"}, {rd_opcode, 3'(rd_dummy), rd_proto}, {8'h0C, 3'd0, 1'b0});
        end
    endtask

    initial begin
        #4_000_000;
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, gap;
        bit err, held_ok, hold_ok;
        repeat (3) @(negedge clk);
        chk(cur_mode == 1'b0 && cmd_valid == 1'b0 && req_done == 1'b0 && req_err == 1'b0,
            "R11 reset state", {cur_mode, cmd_valid, req_done, req_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_rd("R11");

        for (int i = 0; i < 9; i++) begin
            logic [8:0] v;
            logic m;
            v = VEC[i];
            m = v[0];
            run_req(m, int'(v[2:1]), int'(v[4:3]), 1'b0, n, err, gap, held_ok, hold_ok);
            chk(n == int'(v[6:5]), $sformatf("R1 R8 vec%0d command count", i), n, v[6:5]);
            chk(err == v[7], $sformatf("R8 vec%0d error flag", i), err, v[7]);
            chk(cur_mode == v[8], $sformatf("R7 vec%0d mode after", i), cur_mode, v[8]);
            chk(held_ok, $sformatf("R7 vec%0d read settings held", i), held_ok, 1);
            check_rd($sformatf("vec%0d", i));
            if (v[4:3] != 0)
                chk(hold_ok, $sformatf("R9 vec%0d command held under stall", i), hold_ok, 1);
            if (n > 0 && m) begin
                chk(ops[0] == 8'h81 && prs[0] == 1'b0 && abs[0] == 3'd3 && hds[0] && dts[0] == 8'hE7 && ads[0] == 32'd0,
                    $sformatf("R2 vec%0d config write", i), {ops[0], dts[0]}, {8'h81, 8'hE7});
            end
            if (n > 0 && !m) begin
                chk(ops[0] == 8'h66 && prs[0] == 1'b1 && abs[0] == 3'd0 && !hds[0],
                    $sformatf("R3 vec%0d first reset cmd", i), ops[0], 8'h66);
            end
            if (n == 2) begin
                chk(ops[1] == 8'h99 && prs[1] == 1'b1 && abs[1] == 3'd0 && !hds[1],
                    $sformatf("R3 vec%0d second reset cmd", i), ops[1], 8'h99);
                chk(gap == WAIT + 1, $sformatf("R4 vec%0d wait gap", i), gap, WAIT + 1);
            end
        end

        // R10: a request pulse during an entry sequence is ignored
        run_req(1'b1, 3, 0, 1'b1, n, err, gap, held_ok, hold_ok);
        chk(n == 1 && !err && cur_mode == 1'b1, "R10 busy request ignored", {n[1:0], err, cur_mode}, {2'd1, 1'b0, 1'b1});
        begin
            bit extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (req_done || cmd_valid) extra = 1;
            end
            chk(!extra && cur_mode == 1'b1, "R10 no extra completion", extra, 0);
        end

        // R4: the completion of an exit also waits after the last command
        begin
            int cyc_resp, cyc_done;
            cyc_resp = -1; cyc_done = -1;
            @(negedge clk); req_valid = 1'b1; req_mode = 1'b0;
            for (int c = 0; c < 500 && cyc_done < 0; c++) begin
                @(negedge clk);
                req_valid = 1'b0;
                cmd_resp_valid = 1'b0;
                if (req_done) cyc_done = c;
                else if (cmd_ready) begin
                    cmd_ready = 1'b0; cmd_resp_valid = 1'b1; cmd_resp_fail = 1'b0; cyc_resp = c;
                end else if (cmd_valid) cmd_ready = 1'b1;
            end
            chk(cyc_done - cyc_resp == WAIT + 1 && cur_mode == 1'b0, "R4 wait before exit completion",
                cyc_done - cyc_resp, WAIT + 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule